// File: doc/BRIEF.md
# Byte-lane asynchronous SRAM controller

This controller sits between a clocked on-chip request port and an external asynchronous static RAM. The RAM is built from four 8-bit banks that together form a 32-bit word, with a 17-bit word address (128K words). Each bank has its own active-low enable. All four banks share one active-low write strobe and one active-low output enable. The controller never relies on memory timing that it does not control. Every phase of a memory cycle is held for a whole number of system clock cycles, set by parameters. Each parameter is the ceiling of the memory's nanosecond figure divided by the clock period. At the default 100 MHz, writes take one setup cycle, one strobe cycle and one recovery cycle. Reads hold the outputs enabled for two cycles: one cycle covers the access time and one gives margin for the input register.

Requests arrive on a valid/ready port that carries an address, a write flag, a 32-bit write word and a 4-bit lane mask. The controller captures a request on the edge where valid and ready are both high. It then drops ready until the memory cycle and its recovery are complete. A requester facing ready low must keep valid high and its fields unchanged until it sees ready high. There is no queueing, so at most one operation is in flight. A read returns its word with a one-cycle response pulse. The response has no back-pressure, so the requester must accept it when it appears. The data bus is split into an output word, an output-drive enable and an input word. A pad ring or a board-level model joins them into the shared bidirectional bus.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready is 1, mem_ce_n is 4'b1111, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0 and rsp_valid is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. Its fields are captured at that edge. req_ready then stays 0 for SETUP_CYC+STROBE_CYC+IDLE_CYC cycles after a write, or READ_CYC+IDLE_CYC cycles after a read, and returns to 1 in the following cycle.
- R3: A write shows SETUP_CYC cycles with mem_we_n=1, then STROBE_CYC cycles with mem_we_n=0, then IDLE_CYC recovery cycles with mem_we_n=1. mem_addr and mem_dq_o hold the captured address and word throughout. mem_dq_oe is 1 in all three phases.
- R4: During the setup and strobe cycles of a write, mem_ce_n[i] is 0 exactly when mask bit i is 1, where lane i is data bits 8i+7:8i. A write with mask 4'b0000 enables no lane and leaves the memory unchanged.
- R5: A read drives mem_ce_n=4'b0000 and mem_oe_n=0 for READ_CYC cycles, with mem_dq_oe=0. The input word is sampled at the end of the last of these cycles. rsp_valid is 1 for exactly the first recovery cycle, and in that cycle rsp_rdata carries the sampled word.
- R6: In the rsp_rdata word, each lane whose mask bit was 0 in the read request reads as 8'h00.
- R7: mem_dq_oe is never 1 while mem_oe_n is 0. In any cycle where mem_dq_oe rises, mem_oe_n was 1 in the cycle before.
- R8: In every cycle with mem_we_n=0, mem_dq_oe is 1 in that cycle, in the cycle before and in the cycle after.
- R9: Whenever req_ready is 1, every lane enable, mem_we_n and mem_oe_n is 1, and mem_dq_oe is 0.
- R10: A full-mask read returns, for each lane, the byte from the most recent write that enabled that lane. If no write has enabled the lane, the read returns the memory's prior content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 32 | Write word |
| req_mask | input | 4 | Lane mask, bit i selects data bits 8i+7:8i |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 32 | Read word with unrequested lanes zeroed |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 4 | Per-lane enables, active low |
| mem_we_n | output | 1 | Shared write strobe, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Word driven toward the memory |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_i | input | 32 | Word read from the data bus |

## Verification
Two things can happen on the same clock edge: a read's recovery ends, and a waiting request is taken. When that request is a write, the bus turnaround and the start of the controller driving the bus coincide. The bench provokes this by issuing reads and writes back to back over a small address set, in ordered and random sequences. It keeps valid high through each busy period, so the next request is taken on the exact edge where ready returns. Every cycle, a behavioural model built from queued per-cycle expectations judges the enables, strobe, output enable, drive enable and returned data. A separate bench memory model with per-lane enables confirms that partial-mask writes merge correctly when the word is read back.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WSET = 3'd1,
    PH_WSTB = 3'd2,
    PH_READ = 3'd3,
    PH_RCVR = 3'd4
  } phase_t;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 1,
  parameter int IDLE_CYC   = 1,
  parameter int READ_CYC   = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output logic   req_ready,
  output logic   accept,
  output logic   sample,
  output phase_t ph_nxt
);

  localparam int MAXC  = max4(SETUP_CYC, STROBE_CYC, IDLE_CYC, READ_CYC);
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);

  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  function automatic logic [CNT_W-1:0] load(int n);
    return CNT_W'(n - 1);
  endfunction

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign sample    = (ph_q == PH_READ) && (cnt_q == '0);

  always_comb begin
    ph_nxt  = ph_q;
    cnt_nxt = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    unique case (ph_q)
      PH_IDLE: if (req_valid) begin
        ph_nxt  = req_write ? PH_WSET : PH_READ;
        cnt_nxt = req_write ? load(SETUP_CYC) : load(READ_CYC);
      end
      PH_WSET: if (cnt_q == '0) begin
        ph_nxt  = PH_WSTB;
        cnt_nxt = load(STROBE_CYC);
      end
      PH_WSTB, PH_READ: if (cnt_q == '0) begin
        ph_nxt  = PH_RCVR;
        cnt_nxt = load(IDLE_CYC);
      end
      PH_RCVR: if (cnt_q == '0) ph_nxt = PH_IDLE;
      default: ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R2

endmodule

// File: rtl/sram_lane_pins.sv
module sram_lane_pins
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  phase_t            ph_nxt,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [LANES-1:0]  mask_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe
);

  logic             wr_q;
  logic             cur_wr;
  logic [LANES-1:0] cur_mask;

  assign cur_wr   = accept ? req_write : wr_q;
  assign cur_mask = accept ? req_mask  : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      mask_q   <= '0;
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      wr_q     <= req_write;
      mask_q   <= req_mask;
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_we_n  <= (ph_nxt != PH_WSTB);
      mem_oe_n  <= (ph_nxt != PH_READ);
      mem_dq_oe <= (ph_nxt == PH_WSET) || (ph_nxt == PH_WSTB) ||
                   ((ph_nxt == PH_RCVR) && cur_wr);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_ce_n[g] <= 1'b1;
      else        mem_ce_n[g] <= !((ph_nxt == PH_READ) ||
                                   (((ph_nxt == PH_WSET) || (ph_nxt == PH_WSTB)) && cur_mask[g]));
    end
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R7
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n)); // R7
  AST_STROBE_NO_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_dq_oe) && mem_dq_oe)); // R8
  AST_STROBE_ENDS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> mem_dq_oe); // R8
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_o) && $stable(mem_ce_n))); // R3
  AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_ce_n == '0)); // R5

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= sample;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rsp_rdata[g*LANE_W +: LANE_W] <= '0;
      else if (sample)
        rsp_rdata[g*LANE_W +: LANE_W] <= mask[g] ? mem_dq_i[g*LANE_W +: LANE_W] : '0;
    end

    AST_UNASKED_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !mask[g]) |-> (rsp_rdata[g*LANE_W +: LANE_W] == '0)); // R6
  end

  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 1,
  parameter int IDLE_CYC   = 1,
  parameter int READ_CYC   = 2,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  logic             accept;
  logic             sample;
  phase_t           ph_nxt;
  logic [LANES-1:0] mask_q;

  sram_lane_seq #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .IDLE_CYC  (IDLE_CYC),
    .READ_CYC  (READ_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .sample   (sample),
    .ph_nxt   (ph_nxt)
  );

  sram_lane_pins #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .ph_nxt   (ph_nxt),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_mask (req_mask),
    .mask_q   (mask_q),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe)
  );

  sram_lane_capture #(
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (sample),
    .mask     (mask_q),
    .mem_dq_i (mem_dq_i),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_ce_n))); // R9

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int SETUP_CYC  = 2;
  localparam int STROBE_CYC = 1;
  localparam int IDLE_CYC   = 2;
  localparam int READ_CYC   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic [3:0]  mem_ce_n;
  logic        mem_we_n, mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_o, mem_dq_i;

  always #5 clk = ~clk;

  sram_lane_ctrl #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
    .IDLE_CYC(IDLE_CYC), .READ_CYC(READ_CYC)
  ) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  function automatic logic [31:0] init_word(int idx);
    return 32'h9E37_79B1 * (idx + 3);
  endfunction

  function automatic logic [16:0] addr_of(int k);
    return 17'((k * 17'h2345 + 17'h1F) & 17'h1FFFF);
  endfunction

  // memory model: per-lane enables, shared strobe and output enable
  logic [31:0] mdl [16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mdl[i] <= init_word(i);
    end else if (!mem_we_n) begin
      for (int i = 0; i < 4; i++)
        if (!mem_ce_n[i]) mdl[mem_addr[3:0]][8*i +: 8] <= mem_dq_o[8*i +: 8];
    end
  end
  always @* begin
    for (int i = 0; i < 4; i++)
      mem_dq_i[8*i +: 8] = (!mem_ce_n[i] && !mem_oe_n && mem_we_n) ?
                           mdl[mem_addr[3:0]][8*i +: 8] : 8'hA5;
  end

  // reference model: queue of expected per-cycle pin states
  typedef struct {
    bit          idle;
    bit          wr;
    logic [3:0]  ce;
    bit          we, oe, drv, rv;
    logic [3:0]  m;
    logic [31:0] rd;
    logic [16:0] a;
    logic [31:0] wd;
  } rec_t;

  rec_t q[$];
  rec_t cur;
  logic [31:0] shd [16];

  function automatic rec_t idle_rec();
    rec_t r;
    r.idle = 1; r.wr = 0; r.ce = 4'hF; r.we = 1; r.oe = 1; r.drv = 0;
    r.rv = 0; r.m = 0; r.rd = 0; r.a = 0; r.wd = 0;
    return r;
  endfunction

  initial cur = idle_rec();

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = idle_rec();
      for (int i = 0; i < 16; i++) shd[i] = init_word(i);
    end else begin
      if (cur.idle && req_valid) begin
        rec_t r;
        r = idle_rec();
        r.idle = 0; r.wr = req_write; r.a = req_addr; r.wd = req_wdata; r.m = req_mask;
        if (req_write) begin
          r.drv = 1; r.ce = ~req_mask;
          for (int i = 0; i < SETUP_CYC; i++) q.push_back(r);
          r.we = 0;
          for (int i = 0; i < STROBE_CYC; i++) q.push_back(r);
          r.we = 1; r.ce = 4'hF;
          for (int i = 0; i < IDLE_CYC; i++) q.push_back(r);
          for (int i = 0; i < 4; i++)
            if (req_mask[i]) shd[req_addr[3:0]][8*i +: 8] = req_wdata[8*i +: 8];
        end else begin
          r.ce = 4'h0; r.oe = 0;
          for (int i = 0; i < READ_CYC; i++) q.push_back(r);
          r.ce = 4'hF; r.oe = 1;
          for (int i = 0; i < 4; i++)
            r.rd[8*i +: 8] = req_mask[i] ? shd[req_addr[3:0]][8*i +: 8] : 8'h00;
          for (int i = 0; i < IDLE_CYC; i++) begin
            r.rv = (i == 0);
            q.push_back(r);
          end
        end
      end
      if (q.size() > 0) cur = q.pop_front();
      else              cur = idle_rec();
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, what, $time, act, exp);
    end
  endtask

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (!finished) begin
      string tg;
      tg = !rst_n ? "R1" : (cur.idle ? "R9" : "");
      chk(req_ready == cur.idle, !rst_n ? "R1" : "R2", "ready", req_ready, cur.idle);
      chk(mem_ce_n == cur.ce, tg != "" ? tg : (cur.wr ? "R4" : "R5"), "lane enables",
          mem_ce_n, cur.ce);
      chk(mem_we_n == cur.we, tg != "" ? tg : "R3", "write strobe", mem_we_n, cur.we);
      chk(mem_oe_n == cur.oe, tg != "" ? tg : "R5", "output enable", mem_oe_n, cur.oe);
      chk(mem_dq_oe == cur.drv, tg != "" ? tg : "R7", "drive enable", mem_dq_oe, cur.drv);
      chk(rsp_valid == cur.rv, !rst_n ? "R1" : "R5", "response valid", rsp_valid, cur.rv);
      if (cur.rv)
        chk(rsp_rdata == cur.rd, (cur.m == 4'hF) ? "R10" : "R6", "read word",
            rsp_rdata, cur.rd);
      if (!cur.idle)
        chk(mem_addr == cur.a, "R3", "address", mem_addr, cur.a);
      if (!cur.idle && cur.drv)
        chk(mem_dq_o == cur.wd, "R3", "write word", mem_dq_o, cur.wd);
      if (rst_n && !mem_we_n)
        chk(mem_dq_oe && prev_oe, "R8", "drive around strobe", {mem_dq_oe, prev_oe}, 2'b11);
      if (rst_n && prev_we_low)
        chk(mem_dq_oe, "R8", "drive after strobe", mem_dq_oe, 1'b1);
      prev_oe = mem_dq_oe;
      prev_we_low = rst_n && !mem_we_n;
    end
  end
  bit prev_we_low = 0;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    compared++;
    mismatched++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    summary();
  end

  // hold valid until taken (back-pressure rule of R2)
  task automatic issue(bit w, int k, logic [31:0] d, logic [3:0] m);
    req_valid = 1; req_write = w; req_addr = addr_of(k); req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pause(int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4 and R10: full write then read back
    issue(1, 0, 32'hDEAD_BEEF, 4'hF);
    issue(0, 0, 32'h0, 4'hF);
    // R4: partial masks merge on one word
    issue(1, 1, 32'h1111_1122, 4'h1);
    issue(1, 1, 32'h3344_5566, 4'h6);
    issue(1, 1, 32'h7788_99AA, 4'h8);
    issue(0, 1, 32'h0, 4'hF);
    // R4: empty mask leaves memory unchanged
    issue(1, 2, 32'hFFFF_FFFF, 4'h0);
    issue(0, 2, 32'h0, 4'hF);
    // R6: masked return
    issue(0, 1, 32'h0, 4'h5);
    issue(0, 1, 32'h0, 4'hA);
    pause(3);
    // R7: read then write back to back, then write then read
    issue(0, 3, 32'h0, 4'hF);
    issue(1, 3, 32'hCAFE_F00D, 4'hC);
    issue(0, 3, 32'h0, 4'hF);
    pause(2);
    for (int n = 0; n < 80; n++) begin
      int k;
      k = int'($urandom_range(0, 15));
      issue(1'($urandom_range(0, 1)), k, $urandom, 4'($urandom_range(0, 15)));
      if ($urandom_range(0, 3) == 0) pause(int'($urandom_range(1, 3)));
    end
    for (int k = 0; k < 16; k++) issue(0, k, 32'h0, 4'hF);
    pause(8);
    summary();
  end

endmodule